// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a 32-pin general-purpose I/O controller that sits on a simple 32-bit register bus. Software sets each pin's direction and, for output pins, its driven value. Input pins pass through a two-flop synchronizer into a pad-status register. Each input pin can also raise an interrupt. The trigger for a pin is chosen by a 2-bit mode field: low level, high level, rising edge or falling edge. An optional per-pin any-edge bit overrides the mode field so that both transitions count.

Trigger events set sticky bits in a status register. Software clears those bits by writing ones to them. The status bits are gated by a mask register and then reduced to interrupt request lines. A build option chooses between one combined request line and two lines, where the first serves pins 0–15 and the second serves pins 16–31. A second build option removes the any-edge register.

Bus reads are combinational from the registers. A write takes effect on the clock edge at which `bus_req_i` and `bus_we_i` are both high.

Top module: `pin_io_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero, and `irq_o`, `pin_o` and `pin_oe_o` are all zero.
- R2: The word offsets are 0x00 data, 0x04 direction, 0x08 pad status, 0x0C mode word for pins 0–15, 0x10 mode word for pins 16–31, 0x14 mask, 0x18 status and 0x1C any-edge. Offsets that are not word aligned, or are 0x20 and above, read as zero and ignore writes. The pad status register is read-only.
- R3: `pin_oe_o` equals the direction register. `pin_o` carries the data bit where the direction bit is 1 and carries 0 where it is 0.
- R4: A data-register read returns data bits for output pins and pad bits for input pins. A pad-status read returns pad bits with the output-pin bits forced to 0.
- R5: A change on `pin_i` is not yet visible in the pad status after one clock edge. It is visible after the third edge.
- R6: Mode field n sits at bits 2n+1:2n of {mode word high, mode word low}. Mode 00 is active-low level and mode 01 is active-high level. An input pin in level mode sets its status bit on every cycle in which the synchronized level equals the active level, including right after a mode write.
- R7: Mode 10 sets the status bit once per rising transition and mode 11 sets it once per falling transition. A stable level sets nothing after a clear.
- R8: An any-edge bit of 1 makes both transitions of that pin set its status bit, whatever its mode field holds.
- R9: Pins whose direction bit is 1 never set status bits.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Status bits are otherwise sticky. If a trigger condition holds in the same cycle as the clear, the set wins.
- R11: With the split option off, `irq_o[0]` is the OR of (status AND mask) and `irq_o[1]` is 0.
- R12: With the split option on, `irq_o[0]` covers masked status bits 0–15 and `irq_o[1]` covers bits 16–31.
- R13: With the any-edge option off, offset 0x1C reads zero, writes to it are ignored, and edges follow the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | NUM_PINS | Write data |
| bus_rdata_o | output | NUM_PINS | Read data (combinational) |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| pin_o | output | NUM_PINS | Driven pin values |
| pin_oe_o | output | NUM_PINS | Output enables |
| irq_o | output | 2 | Interrupt request lines |

## Verification
The hardest case to reach from the ports is a status clear that lands on the same cycle as a still-valid trigger. On the same path, a cleared edge bit must stay cleared while the pin is held steady. The stimulus first holds level-mode pins at their active level and then issues status clears, so that set and clear meet on one edge. It then toggles edge-mode pins, clears them, and re-reads after several idle cycles. Two instances share one bus and one set of pins: one has the any-edge register and a single request line, and the other has split lines and no any-edge register. A single falling transition therefore sets status in one instance and leaves the other untouched.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_DATA    = 3'd0,
    REG_DIR     = 3'd1,
    REG_PAD     = 3'd2,
    REG_CFG_LO  = 3'd3,
    REG_CFG_HI  = 3'd4,
    REG_MASK    = 3'd5,
    REG_STAT    = 3'd6,
    REG_ANYEDGE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_RISE = 2'b10,
    MODE_FALL = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_io_detect.sv
module pin_io_detect
  import pin_io_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]   sync_i,
  input  logic [N-1:0]   pad_i,
  input  logic [N-1:0]   dir_i,
  input  logic [N-1:0]   anyedge_i,
  input  logic [2*N-1:0] cfg_i,
  output logic [N-1:0]   set_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic       lvl;
    logic       chg;
    logic       hit;
    trig_mode_e mode;

    assign lvl  = sync_i[i];
    assign chg  = sync_i[i] ^ pad_i[i];
    assign mode = trig_mode_e'(cfg_i[2*i +: 2]);

    always_comb begin
      hit = 1'b0;
      if (dir_i[i]) begin
        hit = 1'b0;
      end else if (anyedge_i[i]) begin
        hit = chg;
      end else begin
        case (mode)
          MODE_LOW:  hit = !lvl;
          MODE_HIGH: hit = lvl;
          MODE_RISE: hit = chg & lvl;
          MODE_FALL: hit = chg & !lvl;
          default:   hit = 1'b0;
        endcase
      end
    end

    assign set_o[i] = hit;
  end
endmodule

// File: rtl/pin_io_irq.sv
module pin_io_irq #(
  parameter int unsigned N     = 32,
  parameter bit          SPLIT = 1'b0
) (
  input  logic [N-1:0] isr_i,
  input  logic [N-1:0] imr_i,
  output logic [1:0]   irq_o
);
  localparam int unsigned HALF = N / 2;

  logic [N-1:0] pending;
  assign pending = isr_i & imr_i;

  if (SPLIT) begin : g_split
    assign irq_o = {|pending[N-1:HALF], |pending[HALF-1:0]};
  end else begin : g_single
    assign irq_o = {1'b0, |pending};
  end
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
  import pin_io_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          EN_ANYEDGE  = 1'b1,
  parameter bit          SPLIT_IRQ   = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [1:0]          irq_o
);
  localparam int unsigned CFG_W   = 2 * NUM_PINS;
  localparam int unsigned HALF_CW = CFG_W / 2;
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_MSB = IDX_LSB + REG_IDX_W - 1;

  logic [NUM_PINS-1:0] data_q, dir_q, pad_q, mask_q, isr_q, anyedge_q;
  logic [CFG_W-1:0]    cfg_q;
  logic [NUM_PINS-1:0] sync_q, set_w, clr_w;
  logic                addr_ok, wr_en, isr_wr;
  reg_sel_e            sel;

  // decode: word aligned and inside the 8-word window
  assign addr_ok = (bus_addr_i[IDX_LSB-1:0] == '0) &&
                   (bus_addr_i[ADDR_W-1:IDX_MSB+1] == '0);
  assign sel     = reg_sel_e'(bus_addr_i[IDX_MSB:IDX_LSB]);
  assign wr_en   = bus_req_i & bus_we_i & addr_ok;
  assign isr_wr  = wr_en & (sel == REG_STAT);
  assign clr_w   = isr_wr ? bus_wdata_i : '0;

  pin_io_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  pin_io_detect #(.N(NUM_PINS)) u_detect (
    .sync_i   (sync_q),
    .pad_i    (pad_q),
    .dir_i    (dir_q),
    .anyedge_i(anyedge_q),
    .cfg_i    (cfg_q),
    .set_o    (set_w)
  );

  pin_io_irq #(.N(NUM_PINS), .SPLIT(SPLIT_IRQ)) u_irq (
    .isr_i(isr_q),
    .imr_i(mask_q),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_DATA:   data_q <= bus_wdata_i;
        REG_DIR:    dir_q  <= bus_wdata_i;
        REG_CFG_LO: cfg_q[HALF_CW-1:0]     <= bus_wdata_i;
        REG_CFG_HI: cfg_q[CFG_W-1:HALF_CW] <= bus_wdata_i;
        REG_MASK:   mask_q <= bus_wdata_i;
        default:    ;
      endcase
    end
  end

  if (EN_ANYEDGE) begin : g_anyedge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          anyedge_q <= '0;
      else if (wr_en && sel == REG_ANYEDGE) anyedge_q <= bus_wdata_i;
    end
  end else begin : g_no_anyedge
    assign anyedge_q = '0;
  end

  // status: set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_q <= '0;
      isr_q <= '0;
    end else begin
      pad_q <= sync_q;
      isr_q <= (isr_q & ~clr_w) | set_w;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && addr_ok) begin
      case (sel)
        REG_DATA:    bus_rdata_o = (data_q & dir_q) | (pad_q & ~dir_q);
        REG_DIR:     bus_rdata_o = dir_q;
        REG_PAD:     bus_rdata_o = pad_q & ~dir_q;
        REG_CFG_LO:  bus_rdata_o = cfg_q[HALF_CW-1:0];
        REG_CFG_HI:  bus_rdata_o = cfg_q[CFG_W-1:HALF_CW];
        REG_MASK:    bus_rdata_o = mask_q;
        REG_STAT:    bus_rdata_o = isr_q;
        REG_ANYEDGE: bus_rdata_o = anyedge_q;
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assign pin_o    = data_q & dir_q;
  assign pin_oe_o = dir_q;

  assert_status_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_wr |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

  assert_output_pin_no_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q != '0) |=> ((isr_q & ~$past(isr_q) & $past(dir_q)) == '0));

  assert_pad_follows_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (pad_q == $past(sync_q)));

  assert_unmapped_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !addr_ok) |-> (bus_rdata_o == '0));

  assert_masked_irq_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (irq_o == 2'b00));

  if (!EN_ANYEDGE) begin : g_chk_no_anyedge
    assert_anyedge_reads_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && addr_ok && sel == REG_ANYEDGE) |-> (bus_rdata_o == '0));
  end
endmodule

// File: tb/sim_pin_io_ctrl.sv
`timescale 1ns/1ps
module sim_pin_io_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rd0, rd1, po0, po1, oe0, oe1;
  logic [1:0]  irq0, irq1;

  always #2 clk = ~clk;

  pin_io_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rd0),
    .pin_i(pins), .pin_o(po0), .pin_oe_o(oe0), .irq_o(irq0)
  );

  pin_io_ctrl #(.EN_ANYEDGE(1'b0), .SPLIT_IRQ(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rd1),
    .pin_i(pins), .pin_o(po1), .pin_oe_o(oe1), .irq_o(irq1)
  );

  int          n_run = 0, n_fail = 0;
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          chk_kind = 0;

  // kinds: 1 u0 read, 2 u0 irq, 3 u0 pin_o, 4 u0 pin_oe, 5 u1 read, 6 u1 irq
  int          m_kind;
  logic [31:0] m_exp, m_act;
  string       m_tag;
  always @(negedge clk) begin
    #1;
    if (chk_kind != 0 && kind_q.size() > 0) begin
      m_kind = kind_q.pop_front();
      m_exp  = exp_q.pop_front();
      m_tag  = tag_q.pop_front();
      case (m_kind)
        1: m_act = rd0;
        2: m_act = {30'b0, irq0};
        3: m_act = po0;
        4: m_act = oe0;
        5: m_act = rd1;
        default: m_act = {30'b0, irq1};
      endcase
      n_run++;
      if (m_act !== m_exp) begin
        n_fail++;
        $display("FAIL %s: actual %08h expected %08h", m_tag, m_act, m_exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk(input int k, input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    chk_kind = k;
    if (k == 1 || k == 5) begin
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    end
    @(negedge clk);
    chk_kind = 0; bus_req = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(2);
    // R1: reset state, checked while reset is held
    for (int i = 0; i < 8; i++) chk(1, 8'(i * 4), 32'h0, "R1 reg reset");
    chk(2, 0, 32'h0, "R1 irq reset");
    chk(3, 0, 32'h0, "R1 pin_o reset");
    chk(4, 0, 32'h0, "R1 pin_oe reset");
    @(negedge clk); rst_n = 1'b1;

    wr(8'h0C, 32'h5555_5555);
    wr(8'h10, 32'h5555_5555);
    wr(8'h18, 32'hFFFF_FFFF);
    chk(1, 8'h18, 32'h0, "R10 clear after level gone");

    // R2: unmapped and misaligned
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    chk(1, 8'h20, 32'h0, "R2 unmapped read");
    chk(1, 8'h04, 32'h0, "R2 misaligned write ignored");
    chk(1, 8'h0C, 32'h5555_5555, "R2 cfg lo readback");

    // R3: output gating
    wr(8'h00, 32'hA5A5_F00F);
    wr(8'h04, 32'h0000_FFFF);
    chk(3, 0, 32'h0000_F00F, "R3 pin_o gated");
    chk(4, 0, 32'h0000_FFFF, "R3 pin_oe");

    // R4, R9
    set_pins(32'h1234_00FF);
    idle(4);
    chk(1, 8'h00, 32'h1234_F00F, "R4 data read mix");
    chk(1, 8'h08, 32'h1234_0000, "R4 pad read masked");
    chk(1, 8'h18, 32'h1234_0000, "R9 outputs set no status");
    chk(5, 8'h18, 32'h1234_0000, "R9 outputs set no status u1");

    // R5: synchronizer latency
    set_pins(32'h9234_00FF);
    chk(1, 8'h08, 32'h1234_0000, "R5 not yet visible");
    chk(1, 8'h08, 32'h9234_0000, "R5 visible after sync");

    // R6, R10: level hold vs clear
    wr(8'h18, 32'hFFFF_FFFF);
    chk(1, 8'h18, 32'h9234_0000, "R10 set wins over clear");
    set_pins(32'h0000_00FF);
    idle(4);
    chk(1, 8'h18, 32'h9234_0000, "R10 sticky after level drops");
    wr(8'h18, 32'hFFFF_FFFF);
    chk(1, 8'h18, 32'h0, "R10 w1c");
    wr(8'h10, 32'h5555_5554);
    chk(1, 8'h18, 32'h0001_0000, "R6 low level on mode write");

    // R7: edges (pin16 high lvl, pin17 rise, pin18 fall)
    wr(8'h10, 32'h5555_5579);
    wr(8'h18, 32'hFFFF_FFFF);
    chk(1, 8'h18, 32'h0, "R7 clean start");
    set_pins(32'h0006_00FF);
    idle(4);
    chk(1, 8'h18, 32'h0002_0000, "R7 rising only");
    wr(8'h18, 32'hFFFF_FFFF);
    idle(4);
    chk(1, 8'h18, 32'h0, "R7 stable sets nothing");
    set_pins(32'h0000_00FF);
    idle(4);
    chk(1, 8'h18, 32'h0004_0000, "R7 falling only");
    wr(8'h18, 32'hFFFF_FFFF);

    // R8, R13: any-edge on pin17
    wr(8'h1C, 32'h0002_0000);
    chk(1, 8'h1C, 32'h0002_0000, "R8 any-edge readback");
    chk(5, 8'h1C, 32'h0, "R13 any-edge absent reads zero");
    set_pins(32'h0002_00FF);
    idle(4);
    chk(1, 8'h18, 32'h0002_0000, "R8 rise with any-edge");
    chk(5, 8'h18, 32'h0002_0000, "R13 rise by mode");
    wr(8'h18, 32'hFFFF_FFFF);
    set_pins(32'h0000_00FF);
    idle(4);
    chk(1, 8'h18, 32'h0002_0000, "R8 fall with any-edge");
    chk(5, 8'h18, 32'h0, "R13 fall ignored by rise mode");

    // R11: mask
    wr(8'h14, 32'h0000_FFFF);
    chk(2, 0, 32'h0, "R11 masked off");
    wr(8'h14, 32'h0002_0000);
    chk(2, 0, 32'h1, "R11 single line");
    chk(6, 0, 32'h0, "R12 u1 quiet");

    // R12: split lines
    set_pins(32'h0002_00FF);
    idle(4);
    chk(6, 0, 32'h2, "R12 upper line");
    chk(2, 0, 32'h1, "R11 still single line");
    wr(8'h04, 32'h0);
    chk(3, 0, 32'h0, "R3 inputs drive zero");
    wr(8'h14, 32'h0002_0001);
    chk(6, 0, 32'h3, "R12 both lines");
    chk(2, 0, 32'h1, "R11 one line only");
    wr(8'h18, 32'h0002_0000);
    chk(6, 0, 32'h1, "R12 lower line only");
    chk(1, 8'h18, 32'h0000_00FF, "R10 partial clear");
    wr(8'h18, 32'h0000_00FF);
    chk(1, 8'h18, 32'h0000_00FF, "R6 level reasserts after clear");
    chk(1, 8'h08, 32'h0002_00FF, "R4 pad all inputs");

    idle(2);
    if (kind_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", kind_q.size());
    end
    finish_run();
  end
endmodule